// File: doc/BRIEF.md
# Segment Translation Unit with Descriptor Cache

This block turns a segment number plus an offset into a linear address. It holds a small set of segment slots. Each slot keeps the last selector written to it and a hidden copy of the descriptor that selector named. In real mode the translation uses only the selector: the selector is shifted left by four bits, the low 16 bits of the offset are added, and the sum is cut to 20 bits.

In protected mode, writing a selector into a slot starts a descriptor fetch. The selector chooses one of two tables and an entry in it. The block reads two 32-bit words over a plain memory read port and stores the base, limit, granularity flag and access byte in the slot. The block stays busy while the fetch runs. All later translations through that slot use only the stored copy. They add the cached base to the offset and compare the offset with the scaled limit. An offset past the limit raises a fault instead of an address.

A host core drives the slot writes and translation requests. It watches `busy` and waits while `busy` is high.

Top module: `seg_xlat`

## Requirements
- R1: With `prot_en` low, an accepted request returns `xlat_lin = ({sel,4'h0} + xlat_off[15:0]) mod 2^20`, with bits 31:20 zero. Offset bits 31:16 are ignored and no fault is ever raised.
- R2: A slot write accepted with `prot_en` high sets `busy` from the next cycle. It then issues a read at `T + 8*sel[15:3]` followed by a read at that address + 4. T is `ltab_base` when `sel[2]` is 1 and `gtab_base` when it is 0.
- R3: The first word supplies limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. The second word supplies base[23:16] in bits 7:0, the access byte in bits 15:8, limit[19:16] in bits 19:16, the granularity flag in bit 23 and base[31:24] in bits 31:24.
- R4: In protected mode an in-limit request returns `xlat_lin = base + xlat_off` modulo 2^32.
- R5: The effective limit is the 20-bit limit when the granularity flag is 0 and `{limit,12'hFFF}` when it is 1. An offset above it raises `xlat_fault` with `xlat_valid` low. An offset equal to it is valid.
- R6: Translations never issue memory reads, and slot writes in real mode issue none either. `busy` falls in the cycle after the second read returns.
- R7: Every result reports the slot's selector bits 1:0 on `xlat_rpl`. In protected mode it also reports the cached access byte on `xlat_access`.
- R8: While `busy` is high, translation requests produce no valid and no fault, and slot writes are dropped. The slot keeps its earlier selector.
- R9: After reset, `busy`, `mem_rd_req`, `xlat_valid` and `xlat_fault` are low, and every slot holds selector 0.
- R10: Results appear in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_en | input | 1 | 1 = protected mode, 0 = real mode |
| gtab_base | input | 32 | Base address of the global table |
| ltab_base | input | 32 | Base address of the local table |
| seg_wr | input | 1 | Write a selector into a slot |
| seg_wr_slot | input | SW=clog2(NSEG) | Slot to write |
| seg_wr_sel | input | 16 | Selector value |
| xlat_req | input | 1 | Translation request |
| xlat_slot | input | SW | Slot used for translation |
| xlat_off | input | 32 | Offset |
| busy | output | 1 | Descriptor fetch in progress |
| xlat_valid | output | 1 | Linear address valid |
| xlat_fault | output | 1 | Limit fault |
| xlat_lin | output | 32 | Linear address |
| xlat_rpl | output | 2 | Requested privilege level of the slot |
| xlat_access | output | 8 | Cached access byte |
| mem_rd_req | output | 1 | Read request, held until answered |
| mem_rd_addr | output | 32 | Read address |
| mem_rd_valid | input | 1 | One-cycle read response strobe |
| mem_rd_data | input | 32 | Read data |

## Verification
The assertions assume three things about the environment. Both table bases are 8-byte aligned, so every read address is word-aligned. Memory answers each held request with exactly one `mem_rd_valid` pulse. No response arrives while no request is pending. The stimulus keeps within these limits. The table bases are fixed aligned constants, and the memory model counts a latency from the request and answers once, returning words computed from the address. The stimulus drives all writes and requests away from the clock edge. It sweeps every slot in both modes and both tables, and places offsets at the effective limit, one past it, and at the top of the address space.

// File: rtl/segxu_pkg.sv
package segxu_pkg;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] limit;
    logic        gran;
    logic [7:0]  access;
  } seg_desc_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LO   = 2'd1,
    FS_HI   = 2'd2
  } fetch_st_t;

  // Assemble a cached descriptor from its two memory words.
  function automatic seg_desc_t unpack_desc(input logic [31:0] w_lo,
                                            input logic [31:0] w_hi);
    seg_desc_t d;
    d.base   = {w_hi[31:24], w_hi[7:0], w_lo[31:16]};
    d.limit  = {w_hi[19:16], w_lo[15:0]};
    d.gran   = w_hi[23];
    d.access = w_hi[15:8];
    return d;
  endfunction

endpackage

// File: rtl/segxu_fetch.sv
module segxu_fetch
  import segxu_pkg::*;
#(
  parameter int NSEG = 4,
  localparam int SW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [SW-1:0]   start_slot,
  input  logic [15:0]     start_sel,
  input  logic [31:0]     gtab_base,
  input  logic [31:0]     ltab_base,
  output logic            busy,
  output logic            mem_rd_req,
  output logic [31:0]     mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [31:0]     mem_rd_data,
  output logic            done,
  output logic [SW-1:0]   done_slot,
  output seg_desc_t       done_desc
);

  fetch_st_t     st_q, st_d;
  logic [31:0]   addr_q, addr_d;
  logic [31:0]   lo_q;
  logic [SW-1:0] slot_q;
  logic          addr_en, lo_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FS_IDLE: if (start)        st_d = FS_LO;
      FS_LO:   if (mem_rd_valid) st_d = FS_HI;
      FS_HI:   if (mem_rd_valid) st_d = FS_IDLE;
      default:                   st_d = FS_IDLE;
    endcase
  end

  assign addr_en = (st_q == FS_IDLE) && start;
  assign addr_d  = (start_sel[2] ? ltab_base : gtab_base) +
                   {16'h0000, start_sel[15:3], 3'b000};
  assign lo_en   = (st_q == FS_LO) && mem_rd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
      lo_q   <= '0;
      slot_q <= '0;
    end else begin
      st_q <= st_d;
      if (addr_en) begin
        addr_q <= addr_d;
        slot_q <= start_slot;
      end
      if (lo_en) lo_q <= mem_rd_data;
    end
  end

  assign busy        = (st_q != FS_IDLE);
  assign mem_rd_req  = (st_q == FS_LO) || (st_q == FS_HI);
  assign mem_rd_addr = (st_q == FS_HI) ? (addr_q + 32'd4) : addr_q;
  assign done        = (st_q == FS_HI) && mem_rd_valid;
  assign done_slot   = slot_q;
  assign done_desc   = unpack_desc(lo_q, mem_rd_data);

  // R2: an accepted start makes the unit busy on the next cycle
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2: with aligned table bases every read is word-aligned
  assert_rd_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));

  // R6: busy ends the cycle after the final word returns
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R2: the second read follows the first at the next word
  assert_hi_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid && !done) |=>
      (mem_rd_addr == $past(mem_rd_addr) + 32'd4));

endmodule

// File: rtl/segxu_cache.sv
module segxu_cache
  import segxu_pkg::*;
#(
  parameter int NSEG = 4,
  localparam int SW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_we,
  input  logic [SW-1:0]   sel_slot,
  input  logic [15:0]     sel_val,
  input  logic            desc_we,
  input  logic [SW-1:0]   desc_slot,
  input  seg_desc_t       desc_val,
  input  logic [SW-1:0]   rd_slot,
  output logic [15:0]     rd_sel,
  output seg_desc_t       rd_desc
);

  logic [15:0] sel_q  [NSEG];
  seg_desc_t   desc_q [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_slot
    logic sel_en, desc_en;
    assign sel_en  = sel_we  && (sel_slot  == SW'(i));
    assign desc_en = desc_we && (desc_slot == SW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i]  <= '0;
        desc_q[i] <= '0;
      end else begin
        if (sel_en)  sel_q[i]  <= sel_val;
        if (desc_en) desc_q[i] <= desc_val;
      end
    end
  end

  assign rd_sel  = sel_q[rd_slot];
  assign rd_desc = desc_q[rd_slot];

  // R8: selector writes are only accepted outside a fetch, so they never
  // coincide with the descriptor fill
  assert_we_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_we && desc_we));

endmodule

// File: rtl/segxu_agen.sv
module segxu_agen
  import segxu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_ok,
  input  logic        prot,
  input  logic [15:0] ent_sel,
  input  seg_desc_t   ent_desc,
  input  logic [31:0] off,
  output logic        valid_q,
  output logic        fault_q,
  output logic [31:0] lin_q,
  output logic [1:0]  rpl_q,
  output logic [7:0]  acc_q
);

  logic [19:0] real_sum;
  logic [31:0] eff_lim;
  logic        over;
  logic [31:0] lin_d;
  logic        valid_d, fault_d;

  always_comb begin
    real_sum = {ent_sel, 4'h0} + {4'h0, off[15:0]};
    eff_lim  = ent_desc.gran ? {ent_desc.limit, 12'hFFF}
                             : {12'h000, ent_desc.limit};
    over     = off > eff_lim;
    lin_d    = prot ? (ent_desc.base + off) : {12'h000, real_sum};
    valid_d  = req_ok && !(prot && over);
    fault_d  = req_ok && prot && over;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      lin_q   <= '0;
      rpl_q   <= '0;
      acc_q   <= '0;
    end else begin
      valid_q <= valid_d;
      fault_q <= fault_d;
      if (req_ok) begin
        lin_q <= lin_d;
        rpl_q <= ent_sel[1:0];
        acc_q <= ent_desc.access;
      end
    end
  end

  // R1: real-mode results stay within 20 bits and never fault
  assert_real_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && !prot) |=> (valid_q && !fault_q && lin_q[31:20] == 12'h000));

  // R5: a byte-granular limit cannot cover an offset at or above 1M
  assert_byte_lim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && prot && !ent_desc.gran && off[31:20] != 12'h000) |=> fault_q);

  // R5: fault and valid are never reported together
  assert_fault_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && fault_q));

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import segxu_pkg::*;
#(
  parameter int NSEG = 4,
  localparam int SW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_en,
  input  logic [31:0]   gtab_base,
  input  logic [31:0]   ltab_base,
  input  logic          seg_wr,
  input  logic [SW-1:0] seg_wr_slot,
  input  logic [15:0]   seg_wr_sel,
  input  logic          xlat_req,
  input  logic [SW-1:0] xlat_slot,
  input  logic [31:0]   xlat_off,
  output logic          busy,
  output logic          xlat_valid,
  output logic          xlat_fault,
  output logic [31:0]   xlat_lin,
  output logic [1:0]    xlat_rpl,
  output logic [7:0]    xlat_access,
  output logic          mem_rd_req,
  output logic [31:0]   mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [31:0]   mem_rd_data
);

  logic          wr_ok, fetch_go, req_ok;
  logic          fill_we;
  logic [SW-1:0] fill_slot;
  seg_desc_t     fill_desc;
  logic [15:0]   ent_sel;
  seg_desc_t     ent_desc;

  assign wr_ok    = seg_wr && !busy;
  assign fetch_go = wr_ok && prot_en;
  assign req_ok   = xlat_req && !busy;

  segxu_fetch #(.NSEG(NSEG)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (fetch_go),
    .start_slot  (seg_wr_slot),
    .start_sel   (seg_wr_sel),
    .gtab_base   (gtab_base),
    .ltab_base   (ltab_base),
    .busy        (busy),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_data (mem_rd_data),
    .done        (fill_we),
    .done_slot   (fill_slot),
    .done_desc   (fill_desc)
  );

  segxu_cache #(.NSEG(NSEG)) u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_we   (wr_ok),
    .sel_slot (seg_wr_slot),
    .sel_val  (seg_wr_sel),
    .desc_we  (fill_we),
    .desc_slot(fill_slot),
    .desc_val (fill_desc),
    .rd_slot  (xlat_slot),
    .rd_sel   (ent_sel),
    .rd_desc  (ent_desc)
  );

  segxu_agen u_agen (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_ok  (req_ok),
    .prot    (prot_en),
    .ent_sel (ent_sel),
    .ent_desc(ent_desc),
    .off     (xlat_off),
    .valid_q (xlat_valid),
    .fault_q (xlat_fault),
    .lin_q   (xlat_lin),
    .rpl_q   (xlat_rpl),
    .acc_q   (xlat_access)
  );

  // R8: a request made during a fetch yields no result
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req && busy) |=> !(xlat_valid || xlat_fault));

  // R6: a real-mode write never starts a fetch
  assert_real_nofetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(seg_wr && prot_en)) |=> !busy);

  // R10: every accepted request gives exactly one outcome next cycle
  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok |=> $countones({xlat_valid, xlat_fault}) == 1);

endmodule

// File: tb/sim_seg_xlat.sv
module sim_seg_xlat;

  localparam int NSEG = 4;
  localparam int SW   = 2;
  localparam int LAT  = 2;
  localparam logic [31:0] GTAB = 32'h0001_0000;
  localparam logic [31:0] LTAB = 32'h0002_0800;

  logic          clk, rst_n, prot_en;
  logic [31:0]   gtab_base, ltab_base;
  logic          seg_wr;
  logic [SW-1:0] seg_wr_slot, xlat_slot;
  logic [15:0]   seg_wr_sel;
  logic          xlat_req;
  logic [31:0]   xlat_off;
  logic          busy, xlat_valid, xlat_fault;
  logic [31:0]   xlat_lin;
  logic [1:0]    xlat_rpl;
  logic [7:0]    xlat_access;
  logic          mem_rd_req, mem_rd_valid;
  logic [31:0]   mem_rd_addr, mem_rd_data;

  int n_chk, n_bad, rd_cnt, wait_cnt, cyc;
  logic [31:0] la_prev, la_last;
  logic [15:0] msel [NSEG];

  seg_xlat #(.NSEG(NSEG)) u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // memory word contents, computed from the address
  function automatic logic [31:0] mword(input logic [31:0] a);
    logic [31:0] d, b;
    logic [19:0] l;
    logic [7:0]  ac;
    d  = {a[31:3], 3'b000};
    b  = d * 32'h9E37_79B1;
    l  = {4'h0, d[11:4], 8'h3C};
    ac = d[11:4] ^ 8'h92;
    if (a[2]) return {b[31:24], d[3], 3'b000, l[19:16], ac, b[23:16]};
    return {b[15:0], l[15:0]};
  endfunction

  function automatic logic [31:0] daddr(input logic [15:0] s);
    return (s[2] ? LTAB : GTAB) + {16'h0, s[15:3], 3'b000};
  endfunction

  // memory model: one response per held request, after LAT cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rd_valid = 1'b0;
      wait_cnt     = 0;
    end else if (mem_rd_valid) begin
      mem_rd_valid = 1'b0;
    end else if (mem_rd_req) begin
      if (wait_cnt == LAT) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mword(mem_rd_addr);
        la_prev      = la_last;
        la_last      = mem_rd_addr;
        rd_cnt++;
        wait_cnt     = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic seg_write(input int slot, input logic [15:0] s);
    int r0;
    r0 = rd_cnt;
    @(negedge clk);
    seg_wr = 1'b1; seg_wr_slot = SW'(slot); seg_wr_sel = s;
    @(negedge clk);
    seg_wr = 1'b0;
    msel[slot] = s;
    if (prot_en) begin
      chk("R2 busy after write", {31'h0, busy}, 32'h1);
      while (busy) @(negedge clk);
      chk("R2 read count", rd_cnt - r0, 2);
      chk("R2 first read addr", la_prev, daddr(s));
      chk("R2 second read addr", la_last, daddr(s) + 32'd4);
    end else begin
      chk("R6 real write no busy", {31'h0, busy}, 32'h0);
      chk("R6 real write no reads", rd_cnt - r0, 0);
    end
  endtask

  task automatic xlat(input int slot, input logic [31:0] off);
    logic [31:0] d, lo, hi, base, eff, exp;
    logic [19:0] rs;
    int r0;
    r0 = rd_cnt;
    @(negedge clk);
    xlat_req = 1'b1; xlat_slot = SW'(slot); xlat_off = off;
    @(negedge clk);
    xlat_req = 1'b0;
    chk("R7 rpl", {30'h0, xlat_rpl}, {30'h0, msel[slot][1:0]});
    chk("R6 translation no reads", rd_cnt - r0, 0);
    if (!prot_en) begin
      rs = {msel[slot], 4'h0} + {4'h0, off[15:0]};
      chk("R1 R10 real valid", {31'h0, xlat_valid}, 32'h1);
      chk("R1 real no fault", {31'h0, xlat_fault}, 32'h0);
      chk("R1 real address", xlat_lin, {12'h0, rs});
    end else begin
      d    = daddr(msel[slot]);
      lo   = mword(d);
      hi   = mword(d + 32'd4);
      base = {hi[31:24], hi[7:0], lo[31:16]};
      eff  = hi[23] ? {hi[19:16], lo[15:0], 12'hFFF} : {12'h0, hi[19:16], lo[15:0]};
      if (off > eff) begin
        chk("R5 fault raised", {31'h0, xlat_fault}, 32'h1);
        chk("R5 no valid on fault", {31'h0, xlat_valid}, 32'h0);
      end else begin
        exp = base + off;
        chk("R5 R10 valid in limit", {31'h0, xlat_valid}, 32'h1);
        chk("R4 R3 prot address", xlat_lin, exp);
        chk("R7 R3 access byte", {24'h0, xlat_access}, {24'h0, hi[15:8]});
      end
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: busy actual=%0d expected=0", busy);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; rd_cnt = 0; cyc = 0;
    la_prev = '0; la_last = '0;
    rst_n = 1'b0; prot_en = 1'b0;
    gtab_base = GTAB; ltab_base = LTAB;
    seg_wr = 1'b0; seg_wr_slot = '0; seg_wr_sel = '0;
    xlat_req = 1'b0; xlat_slot = '0; xlat_off = '0;
    mem_rd_data = '0;
    for (int i = 0; i < NSEG; i++) msel[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy", {31'h0, busy}, 32'h0);
    chk("R9 mem_rd_req", {31'h0, mem_rd_req}, 32'h0);
    chk("R9 valid", {31'h0, xlat_valid}, 32'h0);
    chk("R9 fault", {31'h0, xlat_fault}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 slots start at selector 0
    for (int s = 0; s < NSEG; s++) xlat(s, 32'hDEAD_8421);

    // R1 real-mode sweep
    for (int s = 0; s < NSEG; s++) begin
      for (int k = 0; k < 8; k++) begin
        seg_write(s, 16'hF000 ^ 16'(k * 16'h2345) ^ 16'(s));
        xlat(s, 32'h0);
        xlat(s, 32'h0000_FFFF);
        xlat(s, 32'hABCD_1234);
        xlat(s, 32'(k * 16'h1F01));
      end
    end

    // R2..R5 protected sweep over both tables
    prot_en = 1'b1;
    for (int t = 0; t < 2; t++) begin
      for (int idx = 0; idx < 16; idx++) begin
        logic [15:0] s;
        logic [31:0] lo, hi, eff;
        int slot;
        slot = idx % NSEG;
        s    = {13'(idx * 37 + t), 1'(t), 2'(idx)};
        seg_write(slot, s);
        lo  = mword(daddr(s));
        hi  = mword(daddr(s) + 32'd4);
        eff = hi[23] ? {hi[19:16], lo[15:0], 12'hFFF} : {12'h0, hi[19:16], lo[15:0]};
        xlat(slot, 32'h0);
        xlat(slot, eff);
        xlat(slot, eff + 32'd1);
        xlat(slot, eff - 32'd1);
        xlat(slot, 32'hFFFF_FFFF);
        xlat(slot, 32'h0000_1234);
      end
    end

    // R8 requests and writes during a fetch are ignored
    begin
      logic [15:0] keep;
      int r0;
      keep = msel[1];
      r0 = rd_cnt;
      @(negedge clk);
      seg_wr = 1'b1; seg_wr_slot = 2'd2; seg_wr_sel = 16'h0107;
      @(negedge clk);
      seg_wr = 1'b0; msel[2] = 16'h0107;
      xlat_req = 1'b1; xlat_slot = 2'd0; xlat_off = 32'h0;
      @(negedge clk);
      xlat_req = 1'b0;
      chk("R8 no valid while busy", {31'h0, xlat_valid}, 32'h0);
      chk("R8 no fault while busy", {31'h0, xlat_fault}, 32'h0);
      seg_wr = 1'b1; seg_wr_slot = 2'd1; seg_wr_sel = 16'h7FF0;
      @(negedge clk);
      seg_wr = 1'b0;
      while (busy) @(negedge clk);
      chk("R8 only one fetch", rd_cnt - r0, 2);
      chk("R8 dropped write kept slot", {16'h0, msel[1]}, {16'h0, keep});
      xlat(1, 32'h0);
      xlat(2, 32'h10);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule